// File: doc/BRIEF.md
# Interrupt-Driven Task Dispatcher

This block decides which of eight tasks a small programmable accelerator core runs next. Every task owns one interrupt request line, a start-address register and a pending flag. A host enables each task with one bit of an enable register. A request is remembered in the task's pending flag until it is served. When the core is idle, the dispatcher picks one task that is both pending and enabled. It hands that task's start address to the fetch unit and marks the core busy.

Tasks never nest. While one task runs, all other requests only collect as pending flags. The running task ends when the execute stage reports that its stop instruction has reached execution. At that point the dispatcher sends a one-cycle completion interrupt to the host on the line of the finished task, and it can dispatch again on the next cycle. The host can also start a task in software, clear pending flags, and select a one-shot mode. One-shot mode removes a task's enable bit when that task is launched, which helps during debug.

Top module: `tsk_dispatch`

## Requirements
- R1: A request input held high in a cycle sets the pending flag of that task. The flag is visible on `pend_o` from the next cycle on, and it stays set until the task is launched or the host clears it.
- R2: While `busy` is high no launch happens. Requests that arrive during a task are only recorded as pending.
- R3: A task is launched only when its bit in `ier_o` is set. A pending request of a disabled task is kept, and it is launched after the enable bit is written to 1.
- R4: When the dispatcher is idle and some task is pending and enabled, the next cycle shows a one-cycle `launch_valid` pulse. In that cycle `launch_id` is the task number and `launch_addr` is the vector last written for that task. `busy` rises in the same cycle.
- R5: If several enabled tasks are pending together, the task with the lowest number is launched first.
- R6: A task's pending flag clears when the task launches. A request on the same line during the launch cycle or during the run sets the flag again.
- R7: `stop_exec` high while `busy` is high makes `busy` low on the next cycle. In that same cycle, bit `launch_id` of `eot_irq` (the running task) pulses for one cycle. `stop_exec` while idle has no effect.
- R8: If `oneshot_en` is high in the cycle a task is chosen, that task's bit in `ier_o` reads 0 from the launch cycle on.
- R9: A force write (`frc_we`) sets the pending flags of the bits set in `frc_wdata`. A clear write (`pclr_we`) clears the flags of the bits set in `pclr_wdata`. Setting wins over clearing in the same cycle, and this includes a request input.
- R10: After reset, pending flags, enable bits, `busy`, `launch_valid` and `eot_irq` are all 0, and every vector is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_TASK | Request lines, one per task |
| vec_we | input | 1 | Write strobe for a start vector |
| vec_idx | input | IDW | Task selected by a vector write |
| vec_wdata | input | ADDR_W | Start address to store |
| ier_we | input | 1 | Write strobe for the enable register |
| ier_wdata | input | N_TASK | New enable mask |
| frc_we | input | 1 | Write strobe for software start |
| frc_wdata | input | N_TASK | Tasks to mark pending |
| pclr_we | input | 1 | Write strobe for pending clear |
| pclr_wdata | input | N_TASK | Pending flags to clear |
| oneshot_en | input | 1 | Clear a task's enable bit when the task launches |
| stop_exec | input | 1 | Stop instruction of the running task is executing |
| launch_valid | output | 1 | One-cycle start pulse to fetch |
| launch_id | output | IDW | Number of the launched or running task |
| launch_addr | output | ADDR_W | Start address of the launched task |
| busy | output | 1 | A task is running |
| eot_irq | output | N_TASK | Per-task completion pulse to the host |
| ier_o | output | N_TASK | Enable register readback |
| pend_o | output | N_TASK | Pending flag readback |

## Verification
The block's results arrive on a fixed schedule:
- A request or force write shows on `pend_o` one cycle later.
- A launch shows two cycles after the request, or one cycle after the write that enables an already pending task.
- A stop shows as falling `busy` and the completion pulse one cycle later.
- The next launch follows one cycle after that.

The bench drives inputs on falling edges and samples outputs on the falling edge that follows the register in question. Each launch and completion is queued as an expected item when the stimulus is issued. A monitor compares every `launch_valid` and `eot_irq` pulse against the head of its queue. Any pulse that arrives with an empty queue counts as a failure.

// File: rtl/tsk_dispatch_pkg.sv
package tsk_dispatch_pkg;

    // Dispatcher sequencing state
    typedef enum logic {
        DISP_IDLE = 1'b0,
        DISP_RUN  = 1'b1
    } disp_state_e;

    // Index width for a task count, at least one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tsk_pend_bank.sv
// Pending flags: set by request/force, cleared by host or by launch; set wins.
module tsk_pend_bank #(
    parameter int N_TASK = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TASK-1:0] set_i,
    input  logic [N_TASK-1:0] host_clr_i,
    input  logic [N_TASK-1:0] launch_clr_i,
    output logic [N_TASK-1:0] pend_o
);

    typedef struct packed {
        logic [N_TASK-1:0] pend;
    } pend_s;

    pend_s s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pend = (s_q.pend & ~host_clr_i & ~launch_clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;

endmodule

// File: rtl/tsk_first_pick.sv
// Fixed priority: lowest index wins. Built as a prefix-OR chain.
module tsk_first_pick #(
    parameter int N_TASK = 8,
    localparam int IDW   = tsk_dispatch_pkg::idx_width(N_TASK)
) (
    input  logic [N_TASK-1:0] req_i,
    output logic [N_TASK-1:0] grant_o,
    output logic [IDW-1:0]    gid_o,
    output logic              any_o
);

    logic [N_TASK:0] seen;

    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < N_TASK; gi++) begin : g_chain
        assign grant_o[gi]  = req_i[gi] & ~seen[gi];
        assign seen[gi + 1] = seen[gi] | req_i[gi];
    end

    assign any_o = seen[N_TASK];

    always_comb begin
        gid_o = '0;
        for (int i = 0; i < N_TASK; i++) begin
            if (grant_o[i]) gid_o = gid_o | IDW'(i);
        end
    end

endmodule

// File: rtl/tsk_vec_file.sv
// Per-task start address registers with one write and one read port.
module tsk_vec_file #(
    parameter int N_TASK = 8,
    parameter int ADDR_W = 16,
    localparam int IDW   = tsk_dispatch_pkg::idx_width(N_TASK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDW-1:0]    wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [IDW-1:0]    rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o
);

    typedef struct packed {
        logic [N_TASK-1:0][ADDR_W-1:0] vec;
    } vec_s;

    vec_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) s_d.vec[wr_idx_i] = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data_o = s_q.vec[rd_idx_i];

endmodule

// File: rtl/tsk_dispatch.sv
// Non-nesting task dispatcher for an accelerator core.
module tsk_dispatch #(
    parameter int N_TASK = 8,
    parameter int ADDR_W = 16,
    localparam int IDW   = tsk_dispatch_pkg::idx_width(N_TASK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TASK-1:0] irq_req,
    input  logic              vec_we,
    input  logic [IDW-1:0]    vec_idx,
    input  logic [ADDR_W-1:0] vec_wdata,
    input  logic              ier_we,
    input  logic [N_TASK-1:0] ier_wdata,
    input  logic              frc_we,
    input  logic [N_TASK-1:0] frc_wdata,
    input  logic              pclr_we,
    input  logic [N_TASK-1:0] pclr_wdata,
    input  logic              oneshot_en,
    input  logic              stop_exec,
    output logic              launch_valid,
    output logic [IDW-1:0]    launch_id,
    output logic [ADDR_W-1:0] launch_addr,
    output logic              busy,
    output logic [N_TASK-1:0] eot_irq,
    output logic [N_TASK-1:0] ier_o,
    output logic [N_TASK-1:0] pend_o
);

    import tsk_dispatch_pkg::*;

    typedef struct packed {
        disp_state_e       st;
        logic [IDW-1:0]    run_id;
        logic [N_TASK-1:0] ier;
        logic              lv;
        logic [ADDR_W-1:0] laddr;
        logic [N_TASK-1:0] eot;
    } disp_s;

    disp_s s_d, s_q;

    logic [N_TASK-1:0] pend_w;
    logic [N_TASK-1:0] cand_w;
    logic [N_TASK-1:0] grant_w;
    logic [IDW-1:0]    gid_w;
    logic              any_w;
    logic              do_launch;
    logic [N_TASK-1:0] set_w;
    logic [N_TASK-1:0] hclr_w;
    logic [N_TASK-1:0] lclr_w;
    logic [ADDR_W-1:0] vec_rd_w;

    // R1/R9: request lines and software start both set pending flags
    assign set_w  = irq_req | (frc_we ? frc_wdata : '0);
    assign hclr_w = pclr_we ? pclr_wdata : '0;

    // R3: only enabled tasks compete
    assign cand_w    = pend_w & s_q.ier;
    // R2: launch only from idle
    assign do_launch = (s_q.st == DISP_IDLE) && any_w;
    // R6: launched task's flag is dropped
    assign lclr_w    = do_launch ? grant_w : '0;

    tsk_pend_bank #(
        .N_TASK(N_TASK)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_w),
        .host_clr_i  (hclr_w),
        .launch_clr_i(lclr_w),
        .pend_o      (pend_w)
    );

    tsk_first_pick #(
        .N_TASK(N_TASK)
    ) u_pick (
        .req_i  (cand_w),
        .grant_o(grant_w),
        .gid_o  (gid_w),
        .any_o  (any_w)
    );

    tsk_vec_file #(
        .N_TASK(N_TASK),
        .ADDR_W(ADDR_W)
    ) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (vec_we),
        .wr_idx_i (vec_idx),
        .wr_data_i(vec_wdata),
        .rd_idx_i (gid_w),
        .rd_data_o(vec_rd_w)
    );

    always_comb begin
        s_d     = s_q;
        s_d.lv  = 1'b0;
        s_d.eot = '0;
        if (ier_we) s_d.ier = ier_wdata;

        if (do_launch) begin
            s_d.st     = DISP_RUN;
            s_d.run_id = gid_w;
            s_d.lv     = 1'b1;
            s_d.laddr  = vec_rd_w;
            // R8: one-shot removes the enable of the starting task
            if (oneshot_en) s_d.ier = s_d.ier & ~grant_w;
        end else if ((s_q.st == DISP_RUN) && stop_exec) begin
            // R7: end of task, per-task completion pulse
            s_d.st             = DISP_IDLE;
            s_d.eot[s_q.run_id] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= DISP_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign launch_valid = s_q.lv;
    assign launch_id    = s_q.run_id;
    assign launch_addr  = s_q.laddr;
    assign busy         = (s_q.st == DISP_RUN);
    assign eot_irq      = s_q.eot;
    assign ier_o        = s_q.ier;
    assign pend_o       = pend_w;

endmodule

// File: rtl/tsk_dispatch_chk.sv
module tsk_dispatch_chk #(
    parameter int N_TASK = 8,
    localparam int IDW   = tsk_dispatch_pkg::idx_width(N_TASK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_TASK-1:0] irq_req,
    input logic              frc_we,
    input logic              oneshot_en,
    input logic              stop_exec,
    input logic              launch_valid,
    input logic [IDW-1:0]    launch_id,
    input logic              busy,
    input logic [N_TASK-1:0] eot_irq,
    input logic [N_TASK-1:0] ier_o,
    input logic [N_TASK-1:0] pend_o
);

    logic [N_TASK-1:0] ier_prev, pend_prev, irq_prev;
    logic              frc_prev, osh_prev, busy_prev, stop_prev;
    logic [N_TASK-1:0] lower_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier_prev  <= '0;
            pend_prev <= '0;
            irq_prev  <= '0;
            frc_prev  <= 1'b0;
            osh_prev  <= 1'b0;
            busy_prev <= 1'b0;
            stop_prev <= 1'b0;
        end else begin
            ier_prev  <= ier_o;
            pend_prev <= pend_o;
            irq_prev  <= irq_req;
            frc_prev  <= frc_we;
            osh_prev  <= oneshot_en;
            busy_prev <= busy;
            stop_prev <= stop_exec;
        end
    end

    assign lower_mask = (N_TASK'(1) << launch_id) - N_TASK'(1);

    a_r2_no_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> !busy_prev);

    a_r3_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> ier_prev[launch_id]);

    a_r4_busy_with_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> busy);

    a_r5_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        launch_valid |-> ((pend_prev & ier_prev & lower_mask) == '0));

    a_r6_flag_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && (irq_prev == '0) && !frc_prev) |-> !pend_o[launch_id]);

    a_r7_eot_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eot_irq));

    a_r7_eot_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_irq != '0) |-> (stop_prev && busy_prev && !busy));

    a_r8_oneshot_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && osh_prev) |-> !ier_o[launch_id]);

endmodule

bind tsk_dispatch tsk_dispatch_chk #(.N_TASK(N_TASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .frc_we      (frc_we),
    .oneshot_en  (oneshot_en),
    .stop_exec   (stop_exec),
    .launch_valid(launch_valid),
    .launch_id   (launch_id),
    .busy        (busy),
    .eot_irq     (eot_irq),
    .ier_o       (ier_o),
    .pend_o      (pend_o)
);

// File: tb/tsk_dispatch_test.sv
`timescale 1ns/1ps
module tsk_dispatch_test;

    localparam int N  = 8;
    localparam int AW = 16;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          vec_we = 1'b0;
    logic [IW-1:0] vec_idx = '0;
    logic [AW-1:0] vec_wdata = '0;
    logic          ier_we = 1'b0;
    logic [N-1:0]  ier_wdata = '0;
    logic          frc_we = 1'b0;
    logic [N-1:0]  frc_wdata = '0;
    logic          pclr_we = 1'b0;
    logic [N-1:0]  pclr_wdata = '0;
    logic          oneshot_en = 1'b0;
    logic          stop_exec = 1'b0;
    logic          launch_valid;
    logic [IW-1:0] launch_id;
    logic [AW-1:0] launch_addr;
    logic          busy;
    logic [N-1:0]  eot_irq;
    logic [N-1:0]  ier_o;
    logic [N-1:0]  pend_o;

    int checks = 0;
    int fails  = 0;
    int launch_q[$];
    int eot_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tsk_dispatch #(.N_TASK(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .vec_we(vec_we), .vec_idx(vec_idx), .vec_wdata(vec_wdata),
        .ier_we(ier_we), .ier_wdata(ier_wdata),
        .frc_we(frc_we), .frc_wdata(frc_wdata),
        .pclr_we(pclr_we), .pclr_wdata(pclr_wdata),
        .oneshot_en(oneshot_en), .stop_exec(stop_exec),
        .launch_valid(launch_valid), .launch_id(launch_id),
        .launch_addr(launch_addr), .busy(busy), .eot_irq(eot_irq),
        .ier_o(ier_o), .pend_o(pend_o)
    );

    function automatic logic [AW-1:0] vec_of(input int id);
        return AW'(16'h0100 + id * 16);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_irq(input logic [N-1:0] m);
        irq_req = m; tick(1); irq_req = '0;
    endtask

    task automatic wr_ier(input logic [N-1:0] v);
        ier_we = 1'b1; ier_wdata = v; tick(1); ier_we = 1'b0;
    endtask

    task automatic wr_frc(input logic [N-1:0] v);
        frc_we = 1'b1; frc_wdata = v; tick(1); frc_we = 1'b0;
    endtask

    task automatic wr_clr(input logic [N-1:0] v);
        pclr_we = 1'b1; pclr_wdata = v; tick(1); pclr_we = 1'b0;
    endtask

    task automatic do_stop();
        stop_exec = 1'b1; tick(1); stop_exec = 1'b0;
    endtask

    // Monitor: compare each launch / completion pulse with the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (launch_valid) begin
                if (launch_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected launch", int'(launch_id), -1);
                end else begin
                    int e;
                    e = launch_q.pop_front();
                    chk(int'(launch_id) == e, "R4 launch id", int'(launch_id), e);
                    chk(launch_addr == vec_of(e), "R4 launch addr",
                        int'(launch_addr), int'(vec_of(e)));
                end
            end
            if (eot_irq != '0) begin
                if (eot_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected completion", int'(eot_irq), 0);
                end else begin
                    int e;
                    e = eot_q.pop_front();
                    chk(eot_irq == N'(1 << e), "R7 completion line",
                        int'(eot_irq), 1 << e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10 reset state
        chk(pend_o == '0, "R10 pend", int'(pend_o), 0);
        chk(ier_o == '0, "R10 ier", int'(ier_o), 0);
        chk(!busy && !launch_valid && eot_irq == '0, "R10 idle", int'(busy), 0);

        for (int i = 0; i < N; i++) begin
            vec_we = 1'b1; vec_idx = IW'(i); vec_wdata = vec_of(i);
            tick(1);
        end
        vec_we = 1'b0;

        // R1/R3: request of disabled task is latched, not launched
        pulse_irq(8'h08);
        chk(pend_o == 8'h08, "R1 pend set", int'(pend_o), 8'h08);
        tick(3);
        chk(!busy && pend_o == 8'h08, "R3 held while disabled", int'(pend_o), 8'h08);

        // R3/R4: enabling launches the held task one cycle after the write
        launch_q.push_back(3);
        wr_ier(8'hFF);
        tick(1);
        chk(busy, "R4 busy on launch", int'(busy), 1);
        chk(pend_o == 8'h00, "R6 flag cleared at launch", int'(pend_o), 0);

        // R2/R6: requests during run stay pending, own line re-arms
        pulse_irq(8'h2A);
        chk(pend_o == 8'h2A, "R2 pending during run", int'(pend_o), 8'h2A);
        tick(2);
        chk(busy && pend_o == 8'h2A, "R2 no nesting", int'(pend_o), 8'h2A);

        // R7/R5: stop, then lowest pending task next
        eot_q.push_back(3); launch_q.push_back(1);
        do_stop();
        chk(!busy, "R7 busy drops after stop", int'(busy), 0);
        tick(1);
        chk(busy && pend_o == 8'h28, "R5 lowest launched", int'(pend_o), 8'h28);
        eot_q.push_back(1); launch_q.push_back(3);
        do_stop(); tick(1);
        eot_q.push_back(3); launch_q.push_back(5);
        do_stop(); tick(1);
        eot_q.push_back(5);
        do_stop(); tick(2);
        chk(!busy && pend_o == '0, "R7 all done", int'(pend_o), 0);
        // R7: stop while idle does nothing
        do_stop(); tick(2);
        chk(!busy && eot_irq == '0, "R7 idle stop ignored", int'(eot_irq), 0);

        // R9: force, clear, and set-over-clear
        wr_ier(8'h00);
        wr_frc(8'h84);
        chk(pend_o == 8'h84, "R9 force sets", int'(pend_o), 8'h84);
        wr_clr(8'h04);
        chk(pend_o == 8'h80, "R9 clear", int'(pend_o), 8'h80);
        frc_we = 1'b1; frc_wdata = 8'h40; pclr_we = 1'b1; pclr_wdata = 8'h40;
        tick(1);
        frc_we = 1'b0; pclr_we = 1'b0;
        chk(pend_o == 8'hC0, "R9 set wins", int'(pend_o), 8'hC0);
        tick(2);
        chk(!busy, "R3 disabled force not run", int'(busy), 0);

        // R8: one-shot clears enable bit at launch
        oneshot_en = 1'b1;
        launch_q.push_back(6);
        wr_ier(8'h40);
        tick(1);
        chk(busy && ier_o == 8'h00, "R8 one-shot clear", int'(ier_o), 0);
        eot_q.push_back(6);
        do_stop(); tick(1);
        launch_q.push_back(7);
        wr_ier(8'h80);
        tick(1);
        chk(ier_o == 8'h00 && pend_o == 8'h00, "R8 one-shot second", int'(ier_o), 0);
        eot_q.push_back(7);
        do_stop(); tick(1);
        oneshot_en = 1'b0;

        // R6: request in the launch cycle re-arms the flag
        wr_frc(8'h01);
        launch_q.push_back(0);
        wr_ier(8'h01);
        pulse_irq(8'h01);
        chk(busy && pend_o == 8'h01, "R6 re-armed in launch cycle", int'(pend_o), 1);
        eot_q.push_back(0); launch_q.push_back(0);
        do_stop(); tick(1);
        chk(busy && pend_o == 8'h00, "R6 relaunch", int'(pend_o), 0);
        eot_q.push_back(0);
        do_stop(); tick(3);

        chk(launch_q.size() == 0, "R4 all launches seen", launch_q.size(), 0);
        chk(eot_q.size() == 0, "R7 all completions seen", eot_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule